// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Logic

This block decides when a small microcontroller core leaves its instruction stream to serve an interrupt, and where it goes. Two sources feed it: the host writing into the input buffer (host write strobe and chip select both low), and a one-cycle overflow pulse from the timer. Each source has its own pair of enable and disable pulses decoded by the core. A source is latched as pending whether or not it is enabled.

Requests are acted on only at instruction boundaries. When the core strobes a boundary, no handler is active and an enabled source is pending, the block raises a one-cycle take signal. Together with take it presents a fixed vector for the program counter: one address for the input buffer and another for the timer. Taking a source clears its pending flag and marks a handler active. Further requests wait until the core signals a return that restores status; nesting never happens.

Top module: `irq_pair_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, take is 0 and the vector output is 0. Both enables come out of reset off and neither source is pending, so boundaries with nothing new pending give no take.
- R2: A cycle with host_wr_n and host_cs_n both 0 latches an input-buffer request even while that source is disabled; enabling it later lets the request be taken.
- R3: A disable pulse does not clear a pending request. Once the source is enabled again the request is taken at the next boundary.
- R4: take is 1 for exactly one cycle, the cycle after the clock edge that sampled insn_bound at 1. irq_vec then equals HB_VEC (default 3) for the input-buffer source and TM_VEC (default 7) for the timer.
- R5: When both sources are pending and enabled at the same boundary, the input-buffer source is taken first. The timer is taken at a later boundary after the return.
- R6: No take occurs while a handler is active. The active state ends only on a ret_restore pulse, after which the next boundary can take a waiting request.
- R7: Taking the input-buffer source clears its pending flag, so a boundary after the return with no new host write gives no take.
- R8: Taking the timer source clears its pending flag, so a boundary after the return with no new overflow gives no take.
- R9: A pending and enabled request does not cause a take in cycles where insn_bound is 0.
- R10: The two enables are independent: enabling the timer does not enable the input-buffer source. An enable and a disable pulse for the same source in the same cycle leave that source disabled.
- R11: A cycle in which only one of host_wr_n and host_cs_n is 0 does not latch an input-buffer request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cs_n | input | 1 | Host chip select, active low |
| tmr_ovf | input | 1 | Timer overflow pulse |
| hb_irq_on | input | 1 | Enable pulse for the input-buffer source |
| hb_irq_off | input | 1 | Disable pulse for the input-buffer source |
| tm_irq_on | input | 1 | Enable pulse for the timer source |
| tm_irq_off | input | 1 | Disable pulse for the timer source |
| insn_bound | input | 1 | Instruction boundary strobe |
| ret_restore | input | 1 | Return-with-status-restore pulse, ends the active handler |
| take | output | 1 | One-cycle interrupt-take indication |
| irq_vec | output | VEC_W | Vector address, valid while take is 1 |

## Verification
The checks assume that the core pulses ret_restore only while a handler is active and never in the same cycle as insn_bound. The stimulus follows that rule: each scenario issues a single return after each take, at least two cycles after it. The checks also assume that host strobes and overflow pulses are synchronous to clk. The bench drives every input on the falling edge, so each pulse covers exactly one rising edge. In most scenarios the bench keeps the request sources quiet in the cycle a vector is taken, which keeps the check that a taken request is cleared free of any set-and-clear overlap.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
    localparam int NSRC   = 2;
    localparam int SRC_HB = 0;   // input-buffer source, highest priority
    localparam int SRC_TM = 1;   // timer overflow source

    typedef struct packed {
        logic pend;
        logic en;
    } slot_st_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic req_clr,
    input  logic en_set,
    input  logic en_clr,
    output logic pend,
    output logic en
);
    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a fresh request in the same cycle as a take survives
        if (req_clr) st_d.pend = 1'b0;
        if (req_set) st_d.pend = 1'b1;
        // disable dominates a simultaneous enable
        if (en_set)  st_d.en   = 1'b1;
        if (en_clr)  st_d.en   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign en   = st_q.en;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] ready,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ready[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl
    import irq_pair_pkg::*;
#(
    parameter int VEC_W  = 12,
    parameter int HB_VEC = 3,
    parameter int TM_VEC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_n,
    input  logic             host_cs_n,
    input  logic             tmr_ovf,
    input  logic             hb_irq_on,
    input  logic             hb_irq_off,
    input  logic             tm_irq_on,
    input  logic             tm_irq_off,
    input  logic             insn_bound,
    input  logic             ret_restore,
    output logic             take,
    output logic [VEC_W-1:0] irq_vec
);
    localparam logic [VEC_W-1:0] HB_ADDR = VEC_W'(HB_VEC);
    localparam logic [VEC_W-1:0] TM_ADDR = VEC_W'(TM_VEC);

    typedef struct packed {
        logic             in_svc;
        logic             take;
        logic [VEC_W-1:0] vec;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NSRC-1:0] req_set, en_set, en_clr, req_clr;
    logic [NSRC-1:0] pend, en, ready, grant;
    logic            any_ready;

    assign req_set[SRC_HB] = !host_wr_n && !host_cs_n;
    assign req_set[SRC_TM] = tmr_ovf;
    assign en_set          = {tm_irq_on,  hb_irq_on};
    assign en_clr          = {tm_irq_off, hb_irq_off};
    assign ready           = pend & en;

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        irq_src_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_set (req_set[g]),
            .req_clr (req_clr[g]),
            .en_set  (en_set[g]),
            .en_clr  (en_clr[g]),
            .pend    (pend[g]),
            .en      (en[g])
        );
    end

    irq_pick #(.N(NSRC)) u_pick (
        .ready (ready),
        .grant (grant),
        .any   (any_ready)
    );

    logic take_now;
    assign take_now = insn_bound && !st_q.in_svc && any_ready;
    assign req_clr  = take_now ? grant : '0;

    always_comb begin
        st_d      = st_q;
        st_d.take = take_now;
        st_d.vec  = '0;
        if (take_now) begin
            st_d.in_svc = 1'b1;
            st_d.vec    = grant[SRC_HB] ? HB_ADDR : TM_ADDR;
        end else if (ret_restore) begin
            st_d.in_svc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take    = st_q.take;
    assign irq_vec = st_q.vec;
endmodule

// File: rtl/irq_pair_chk.sv
module irq_pair_chk #(
    parameter int VEC_W  = 12,
    parameter int HB_VEC = 3,
    parameter int TM_VEC = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr_n,
    input logic             host_cs_n,
    input logic             tmr_ovf,
    input logic             insn_bound,
    input logic             take,
    input logic [VEC_W-1:0] irq_vec,
    input logic [1:0]       pend,
    input logic [1:0]       en
);
    // R1: quiet while reset is held
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!take && irq_vec == '0));

    // R4: only the two fixed vectors appear with take
    a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (irq_vec == VEC_W'(HB_VEC) || irq_vec == VEC_W'(TM_VEC)));

    // R9: a take follows a sampled boundary
    a_r9_take_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(insn_bound));

    // R6: no take right after a take (handler active)
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    // R5: timer is never chosen over a ready input-buffer request
    a_r5_hb_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_vec == VEC_W'(TM_VEC)) |-> !$past(pend[0] && en[0]));

    // R7: input-buffer request cleared when taken
    a_r7_hb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_vec == VEC_W'(HB_VEC)) |-> (!pend[0] || $past(!host_wr_n && !host_cs_n)));

    // R8: timer request cleared when taken
    a_r8_tm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_vec == VEC_W'(TM_VEC)) |-> (!pend[1] || $past(tmr_ovf)));
endmodule

bind irq_pair_ctrl irq_pair_chk #(
    .VEC_W (VEC_W),
    .HB_VEC(HB_VEC),
    .TM_VEC(TM_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_n  (host_wr_n),
    .host_cs_n  (host_cs_n),
    .tmr_ovf    (tmr_ovf),
    .insn_bound (insn_bound),
    .take       (take),
    .irq_vec    (irq_vec),
    .pend       (pend),
    .en         (en)
);

// File: tb/tb_irq_pair_ctrl.sv
module tb_irq_pair_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W = 12;
    localparam logic [VEC_W-1:0] V_HB = 12'd3;
    localparam logic [VEC_W-1:0] V_TM = 12'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr_n = 1'b1, host_cs_n = 1'b1, tmr_ovf = 1'b0;
    logic hb_irq_on = 1'b0, hb_irq_off = 1'b0, tm_irq_on = 1'b0, tm_irq_off = 1'b0;
    logic insn_bound = 1'b0, ret_restore = 1'b0;
    logic take;
    logic [VEC_W-1:0] irq_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pair_ctrl #(.VEC_W(VEC_W), .HB_VEC(3), .TM_VEC(7)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr_n(host_wr_n), .host_cs_n(host_cs_n),
        .tmr_ovf(tmr_ovf), .hb_irq_on(hb_irq_on), .hb_irq_off(hb_irq_off),
        .tm_irq_on(tm_irq_on), .tm_irq_off(tm_irq_off), .insn_bound(insn_bound),
        .ret_restore(ret_restore), .take(take), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic pulse(ref logic s, input logic act_val);
        s = act_val; step(); s = ~act_val;
    endtask

    task automatic host_write(); host_wr_n = 0; host_cs_n = 0; step(); host_wr_n = 1; host_cs_n = 1; endtask

    // strobe a boundary; take/vec are registered and visible one edge later
    task automatic boundary(output logic t, output logic [VEC_W-1:0] v);
        insn_bound = 1; step(); insn_bound = 0;
        t = take; v = irq_vec;
        step();
    endtask

    task automatic expect_take(input string req, input logic [VEC_W-1:0] exp_v);
        logic t; logic [VEC_W-1:0] v;
        boundary(t, v);
        chk({req, " take"}, t, 1'b1);
        chk({req, " vec"}, v, exp_v);
        chk({req, " take one cycle"}, take, 1'b0);
    endtask

    task automatic expect_none(input string req);
        logic t; logic [VEC_W-1:0] v;
        boundary(t, v);
        chk({req, " no take"}, t, 1'b0);
    endtask

    task automatic do_return(); step(); pulse(ret_restore, 1'b1); step(); endtask

    task automatic t_reset();
        chk("R1 take in reset", take, 1'b0);
        chk("R1 vec in reset", irq_vec, '0);
        rst_n = 1; step(); step();
        chk("R1 take after reset", take, 1'b0);
        chk("R1 vec after reset", irq_vec, '0);
        expect_none("R1 enables off");
        hb_irq_on = 1; tm_irq_on = 1; step(); hb_irq_on = 0; tm_irq_on = 0;
        expect_none("R1 nothing pending");
        hb_irq_off = 1; tm_irq_off = 1; step(); hb_irq_off = 0; tm_irq_off = 0;
    endtask

    task automatic t_latch_disabled();
        pulse(hb_irq_on, 1'b1);
        host_wr_n = 0; step(); host_wr_n = 1;
        host_cs_n = 0; step(); host_cs_n = 1;
        expect_none("R11 partial strobe");
        pulse(hb_irq_off, 1'b1);
        host_write();
        expect_none("R2 disabled source");
        pulse(hb_irq_on, 1'b1);
        expect_take("R2 latched while disabled", V_HB);
        do_return();
        pulse(hb_irq_off, 1'b1);
    endtask

    task automatic t_disable_keeps();
        pulse(hb_irq_on, 1'b1);
        host_write();
        pulse(hb_irq_off, 1'b1);
        expect_none("R3 disabled pending");
        pulse(hb_irq_on, 1'b1);
        expect_take("R3 pending survives", V_HB);
        do_return();
        expect_none("R7 hb cleared on take");
        pulse(hb_irq_off, 1'b1);
    endtask

    task automatic t_timer();
        pulse(tm_irq_on, 1'b1);
        pulse(tmr_ovf, 1'b1);
        step(); step(); step();
        chk("R9 no take without boundary", take, 1'b0);
        expect_take("R4 timer vector", V_TM);
        do_return();
        expect_none("R8 timer cleared on take");
        pulse(tm_irq_off, 1'b1);
    endtask

    task automatic t_priority();
        hb_irq_on = 1; tm_irq_on = 1; step(); hb_irq_on = 0; tm_irq_on = 0;
        host_wr_n = 0; host_cs_n = 0; tmr_ovf = 1; step();
        host_wr_n = 1; host_cs_n = 1; tmr_ovf = 0;
        expect_take("R5 hb first", V_HB);
        do_return();
        expect_take("R5 timer second", V_TM);
        do_return();
        expect_none("R5 both served");
    endtask

    task automatic t_nesting();
        // both enables still on from the priority scenario
        host_write();
        expect_take("R6 enter hb", V_HB);
        pulse(tmr_ovf, 1'b1);
        expect_none("R6 timer waits in service");
        host_write();
        expect_none("R6 hb waits in service");
        do_return();
        expect_take("R6 hb after return", V_HB);
        do_return();
        expect_take("R6 timer after return", V_TM);
        do_return();
        hb_irq_off = 1; tm_irq_off = 1; step(); hb_irq_off = 0; tm_irq_off = 0;
    endtask

    task automatic t_enable_pairs();
        hb_irq_on = 1; hb_irq_off = 1; step(); hb_irq_on = 0; hb_irq_off = 0;
        host_write();
        expect_none("R10 on+off leaves disabled");
        pulse(tm_irq_on, 1'b1);
        expect_none("R10 timer enable independent");
        pulse(hb_irq_on, 1'b1);
        expect_take("R10 hb after own enable", V_HB);
        do_return();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(); step();
        t_reset();
        t_latch_disabled();
        t_disable_keeps();
        t_timer();
        t_priority();
        t_nesting();
        t_enable_pairs();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule